// File: doc/BRIEF.md
# Serial Byte Receiver with Two-Entry Holding Queue

This block turns an asynchronous, idle-high serial line into bytes. A frame begins with a low start bit. Eight data bits follow, least significant first. An optional parity bit comes next, and the frame ends with a high stop bit. The line is oversampled by a tick input (16 ticks per bit by default), so the baud-rate divider stays outside the block. Reception runs only while `rx_en` is high.

Finished bytes enter a two-entry queue, which is read through a valid/ready output stream. `out_valid` is high whenever at least one byte is held, and `out_data` then presents the oldest byte. A byte leaves the queue on every clock edge where `out_valid` and `out_ready` are both high. The consumer may hold `out_ready` low for as long as it likes. While it does, the queue fills, and then one more byte can still be assembled in the shifter. If that extra byte finishes while both entries are still held, the byte is dropped and the overrun flag is set. `buf_full` reports two held bytes. The level interrupt `rx_irq` follows either the non-empty condition or the full condition, as chosen by `irq_two_sel`.

Top module: `uart_rx2buf`

## Requirements
- R1: While `rx_en` is 0, the line is ignored: no byte is stored and no error flag is set.
- R2: A low level seen on a tick while idle starts a frame. The frame is kept only if the line is still low 8 ticks later, at the middle of the start bit. Otherwise the receiver returns to idle and nothing is stored.
- R3: Each data bit is sampled at its centre (16 ticks apart). The first bit received becomes bit 0 of the byte, and eight bits make the byte.
- R4: When `par_en` is 1, the bit after bit 7 is parity. Even parity (`par_odd`=0) expects that bit to equal the XOR of the data bits; odd parity (`par_odd`=1) expects its inverse. A mismatch sets `err_parity` when the byte is stored.
- R5: A stop bit sampled low sets `err_frame`. The byte is still stored.
- R6: `out_valid` is 1 exactly when one or two bytes are held, and `buf_full` is 1 exactly when two bytes are held. Both are 0 after reset.
- R7: A handshake on a full queue clears `buf_full` and keeps `out_valid`. A handshake on the last byte clears `out_valid`. While `out_valid` is 0, `out_ready` changes nothing.
- R8: A byte that completes while two are held is discarded and sets `err_overrun`, unless a handshake happens in that same cycle, in which case the byte is stored.
- R9: With `irq_two_sel`=0, `rx_irq` equals the non-empty condition. With `irq_two_sel`=1, `rx_irq` is high only when two bytes are held.
- R10: Error flags are sticky until cleared by a one-cycle pulse on `err_clr` (bit 0 overrun, bit 1 parity, bit 2 framing). A new error in the same cycle takes priority over the clear.
- R11: Bytes leave the queue in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| irq_two_sel | input | 1 | Interrupt threshold: 0 = one byte, 1 = two bytes |
| sample_tick | input | 1 | Oversampling tick, 16 per bit period |
| rx_line | input | 1 | Serial input, idle high |
| out_valid | output | 1 | At least one byte held; `out_data` is valid |
| out_ready | input | 1 | Consumer takes the oldest byte |
| out_data | output | 8 | Oldest held byte |
| buf_full | output | 1 | Two bytes held |
| rx_irq | output | 1 | Receive interrupt level |
| err_clr | input | 3 | Write-one-to-clear pulses for the error flags |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity flag |
| err_frame | output | 1 | Sticky framing flag |

## Verification
Byte completion and the consumer handshake can land in the same cycle while the queue is full. In that case, the push of the new byte and the pop of the oldest byte decide between storing the new byte and raising overrun. To provoke this, the bench fills the queue and then pulses `out_ready` once during the third frame's stop bit, sweeping the pulse across every cycle of that bit. Each trial is judged by consistency: either overrun stays clear and the two newest bytes drain in order, or overrun is set and only the older surviving byte drains. Across the sweep, the outcome must change exactly once, from stored to discarded.

// File: rtl/uart_rx2buf_pkg.sv
package uart_rx2buf_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx2buf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          tick,
  input  logic          line_in,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          par_bad,
  output logic          stop_bad
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] T_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] T_MID  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  rx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] sh;
  logic          pbad;
  logic [1:0]    sync;
  logic          ln;

  assign ln = sync[1];

  // two-flop synchroniser, reset to idle level
  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
      pbad <= 1'b0;
    end else if (!en) begin
      st   <= RX_IDLE;
      tcnt <= '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: begin
          tcnt <= '0;
          if (!ln) st <= RX_START;
        end
        RX_START: begin
          if (tcnt == T_MID) begin
            tcnt <= '0;
            bcnt <= '0;
            st   <= ln ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (tcnt == T_LAST) begin
            tcnt <= '0;
            sh   <= {ln, sh[DW-1:1]};
            if (bcnt == B_LAST) begin
              pbad <= 1'b0;
              st   <= par_en ? RX_PAR : RX_STOP;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (tcnt == T_LAST) begin
            tcnt <= '0;
            pbad <= (ln != ((^sh) ^ par_odd));
            st   <= RX_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (tcnt == T_LAST) begin
            tcnt <= '0;
            st   <= RX_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign done     = en && tick && (st == RX_STOP) && (tcnt == T_LAST);
  assign data     = sh;
  assign par_bad  = pbad;
  assign stop_bad = !ln;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          nonempty,
  output logic          full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   P_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] C_FULL = CNTW'(DEPTH);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            do_pop, do_push;

  assign do_pop  = pop && nonempty;
  assign do_push = push && (!full || do_pop);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (do_push && (wp == AW'(g))) mem[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == P_LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == P_LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata    = mem[rp];
  assign nonempty = (cnt != '0);
  assign full     = (cnt == C_FULL);
endmodule

// File: rtl/uart_rx2buf.sv
module uart_rx2buf #(
  parameter int DW    = 8,
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          irq_two_sel,
  input  logic          sample_tick,
  input  logic          rx_line,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          buf_full,
  output logic          rx_irq,
  input  logic [2:0]    err_clr,
  output logic          err_overrun,
  output logic          err_parity,
  output logic          err_frame
);
  localparam int NERR = 3;

  logic          rx_done, par_bad, stop_bad, pop;
  logic [DW-1:0] rx_data;
  logic [NERR-1:0] err_set, err_q;

  uart_rx_deser #(.DW(DW), .OSR(OSR)) u_deser (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .par_en(par_en), .par_odd(par_odd),
    .tick(sample_tick), .line_in(rx_line), .done(rx_done), .data(rx_data),
    .par_bad(par_bad), .stop_bad(stop_bad)
  );

  assign pop = out_valid && out_ready;

  uart_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_done), .wdata(rx_data), .pop(pop),
    .rdata(out_data), .nonempty(out_valid), .full(buf_full)
  );

  // bit 0 overrun, bit 1 parity, bit 2 framing
  assign err_set = {rx_done && stop_bad, rx_done && par_bad, rx_done && buf_full && !pop};

  genvar i;
  generate
    for (i = 0; i < NERR; i++) begin : g_err
      always_ff @(posedge clk) begin
        if (!rst_n)          err_q[i] <= 1'b0;
        else if (err_set[i]) err_q[i] <= 1'b1;
        else if (err_clr[i]) err_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign err_overrun = err_q[0];
  assign err_parity  = err_q[1];
  assign err_frame   = err_q[2];
  assign rx_irq      = irq_two_sel ? buf_full : out_valid;
endmodule

// File: rtl/uart_rx2buf_chk.sv
module uart_rx2buf_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic irq_two_sel,
  input logic out_valid,
  input logic out_ready,
  input logic buf_full,
  input logic rx_irq,
  input logic err_overrun,
  input logic byte_done
);
  assert_full_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> out_valid);

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && $past(!rx_en)) |-> !byte_done);

  assert_empty_read_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !byte_done) |=> !out_valid);

  assert_pop_full_keeps_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && out_ready && !byte_done) |=> (out_valid && !buf_full));

  assert_overrun_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && buf_full && !out_ready) |=> (err_overrun && buf_full));

  assert_irq_two_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_two_sel && !buf_full) |-> !rx_irq);
endmodule

bind uart_rx2buf uart_rx2buf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_two_sel(irq_two_sel),
  .out_valid(out_valid), .out_ready(out_ready), .buf_full(buf_full),
  .rx_irq(rx_irq), .err_overrun(err_overrun), .byte_done(rx_done)
);

// File: tb/uart_rx2buf_tb_top.sv
`timescale 1ns/1ps
module uart_rx2buf_tb_top;
  localparam int BITC = 32; // 16 ticks x tick every 2 cycles

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic irq_two_sel = 1'b0, tick = 1'b0, line = 1'b1, out_ready = 1'b0;
  logic [2:0] err_clr = 3'b000;
  logic out_valid, buf_full, rx_irq, err_overrun, err_parity, err_frame;
  logic [7:0] out_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_rx2buf dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
    .irq_two_sel(irq_two_sel), .sample_tick(tick), .rx_line(line),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .buf_full(buf_full), .rx_irq(rx_irq), .err_clr(err_clr),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame)
  );

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v);
    @(negedge clk) line = v;
    repeat (BITC - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v,
                      input int pop_at);
    hold(1'b0);
    for (int i = 0; i < 8; i++) hold(d[i]);
    if (par_en) hold(par_of(d, par_odd) ^ bad_par);
    for (int i = 0; i < BITC; i++) begin
      @(negedge clk);
      line = stop_v;
      out_ready = (i == pop_at);
    end
    @(negedge clk);
    out_ready = 1'b0;
    line = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic take(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(req, out_valid, 1'b1);
    chk(req, out_data, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic clear_errs;
    @(negedge clk) err_clr = 3'b111;
    @(negedge clk) err_clr = 3'b000;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int first_ov;
    void'($urandom(32'h5eed1));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset valid", out_valid, 0);
    chk("R6 reset full", buf_full, 0);
    chk("R9 reset irq", rx_irq, 0);
    chk("R10 reset errs", {err_frame, err_parity, err_overrun}, 0);
    rx_en = 1'b1;

    // R3: single byte, LSB first
    send(8'hA5, 0, 1, -1);
    chk("R6 one valid", out_valid, 1);
    chk("R6 one not full", buf_full, 0);
    chk("R9 irq one byte", rx_irq, 1);
    take(8'hA5, "R3 data");
    @(negedge clk);
    chk("R7 last read clears valid", out_valid, 0);

    // R7: read from empty changes nothing
    out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    @(negedge clk);
    chk("R7 empty read valid", out_valid, 0);
    chk("R7 empty read full", buf_full, 0);

    // R9 threshold two, R11 order
    irq_two_sel = 1'b1;
    send(8'h3C, 0, 1, -1);
    chk("R9 irq off at one", rx_irq, 0);
    send(8'hC3, 0, 1, -1);
    chk("R6 full", buf_full, 1);
    chk("R9 irq at two", rx_irq, 1);
    take(8'h3C, "R11 oldest first");
    @(negedge clk);
    chk("R7 full read keeps valid", out_valid, 1);
    chk("R7 full read clears full", buf_full, 0);
    take(8'hC3, "R11 second");
    irq_two_sel = 1'b0;

    // R8 overrun discards third byte
    send(8'h11, 0, 1, -1);
    send(8'h22, 0, 1, -1);
    send(8'h33, 0, 1, -1);
    chk("R8 overrun set", err_overrun, 1);
    take(8'h11, "R8 keep first");
    take(8'h22, "R8 keep second");
    @(negedge clk);
    chk("R8 third dropped", out_valid, 0);
    @(negedge clk) err_clr = 3'b001;
    @(negedge clk) err_clr = 3'b000;
    chk("R10 overrun cleared", err_overrun, 0);

    // R4 parity
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h7E, 0, 1, -1);
    chk("R4 even good", err_parity, 0);
    take(8'h7E, "R4 even data");
    send(8'h81, 1, 1, -1);
    chk("R4 even bad", err_parity, 1);
    take(8'h81, "R4 bad data stored");
    clear_errs();
    par_odd = 1'b1;
    send(8'h5B, 0, 1, -1);
    chk("R4 odd good", err_parity, 0);
    take(8'h5B, "R4 odd data");
    send(8'h5B, 1, 1, -1);
    chk("R4 odd bad", err_parity, 1);
    take(8'h5B, "R4 odd bad data");
    clear_errs();
    chk("R10 parity cleared", err_parity, 0);
    par_en = 1'b0;

    // R5 framing
    send(8'h96, 0, 0, -1);
    chk("R5 frame err", err_frame, 1);
    take(8'h96, "R5 byte kept");
    clear_errs();
    chk("R10 all cleared", {err_frame, err_parity, err_overrun}, 0);

    // R1 disabled
    rx_en = 1'b0;
    send(8'h00, 0, 0, -1);
    @(negedge clk);
    chk("R1 nothing stored", out_valid, 0);
    chk("R1 no errors", {err_frame, err_parity, err_overrun}, 0);
    rx_en = 1'b1;
    repeat (40) @(negedge clk);

    // R2 short glitch is rejected
    @(negedge clk) line = 1'b0;
    repeat (5) @(negedge clk);
    line = 1'b1;
    repeat (600) @(negedge clk);
    chk("R2 glitch ignored", out_valid, 0);
    chk("R2 glitch no frame err", err_frame, 0);

    // R8 sweep of a single handshake across the third frame's stop bit
    first_ov = -1;
    for (int k = 0; k < BITC; k++) begin
      logic [7:0] b0, b1, b2;
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
      send(b0, 0, 1, -1);
      send(b1, 0, 1, -1);
      send(b2, 0, 1, k);
      if (err_overrun) begin
        if (first_ov < 0) first_ov = k;
        take(b1, "R8 sweep overrun survivor");
      end else begin
        if (first_ov >= 0) chk("R8 sweep monotonic", k, first_ov - 1);
        take(b1, "R8 sweep stored older");
        take(b2, "R8 sweep stored newer");
      end
      @(negedge clk);
      chk("R8 sweep drained", out_valid, 0);
      clear_errs();
    end
    chk("R8 sweep early no overrun", (first_ov > 0), 1);
    chk("R8 sweep late overrun", (first_ov >= 0 && first_ov < BITC), 1);

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      logic bp, sv;
      d = 8'($urandom);
      par_en = 1'($urandom);
      par_odd = 1'($urandom);
      bp = par_en && ($urandom_range(0, 5) == 0);
      sv = ($urandom_range(0, 7) != 0);
      send(d, bp, sv, -1);
      chk("R4 random parity flag", err_parity, bp);
      chk("R5 random frame flag", err_frame, !sv);
      take(d, "R3 random data");
      clear_errs();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule